// File: doc/BRIEF.md
# Banked Comparator Register Window

This block holds the setup registers for four match comparators. A bus master reaches all four through one 8-byte register window. A bank-select input picks which comparator the window currently shows. Two of the comparators are full banks. Each full bank holds a control byte, a 24-bit address compare value, a 16-bit data compare value and a 16-bit data mask. The other two are reduced banks that hold only the control byte and the address compare value.

The bus is byte-wide and has a 3-bit offset. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from the selected bank and offset. The stored values are driven straight out to the comparator match logic, which sits outside this block.

On a reduced bank:
- The data and mask positions read as zero and drop writes.
- The control byte keeps only the bits named by a parameter mask, so its layout differs from a full bank.

Top module: `cbw_window`

## Requirements
- R1: While `rst_n` is low, every stored register is cleared, so all compare outputs are zero and every readable byte is zero.
- R2: A write changes only the selected bank. The registers of the other three banks keep their values.
- R3: The window offsets are:
  - 0: control.
  - 1, 2 and 3: address bits 23:16, 15:8 and 7:0.
  - 4 and 5: data compare bits 15:8 and 7:0.
  - 6 and 7: data mask bits 15:8 and 7:0.
- R4: On a reduced bank (`bank_sel` 1 or 3 by default), offsets 4 to 7 read as zero. Writes there change no output, and the bank's `data_out` and `mask_out` slices stay zero.
- R5: On a reduced bank, the control byte stores `wdata & 8'hE7`, so bits 4 and 3 read as zero. On a full bank all 8 control bits are stored.
- R6: `rdata` shows the selected bank's byte at `offset` in the same cycle, including a value written at the previous edge.
- R7: A change of `bank_sel` applies to the very next access with no wait cycle, including back-to-back writes to different banks.
- R8: When `wr_en` is low, no register changes, whatever `wdata`, `offset` and `bank_sel` do.
- R9: Bank n's values appear at the slice of index n in each output vector:
  - `ctrl_out[8n+:8]`
  - `addr_out[24n+:24]`
  - `data_out[16n+:16]`
  - `mask_out[16n+:16]`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Bank shown in the window (0..3) |
| wr_en | input | 1 | Write strobe for the current offset |
| offset | input | 3 | Byte offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected bank and offset |
| ctrl_out | output | 32 | Control bytes of all banks |
| addr_out | output | 96 | Address compare values of all banks |
| data_out | output | 64 | Data compare values (zero for reduced banks) |
| mask_out | output | 64 | Data mask values (zero for reduced banks) |

## Verification
The assertions assume that `bank_sel`, `offset`, `wr_en` and `wdata` are settled before each rising edge. They also assume that `rst_n` starts low. The bench meets both conditions: it drives every input on the falling edge and holds reset for several cycles from time zero.

Stimulus covers both bank kinds and all offsets, both directly and from a vector table. It also covers writes to reduced-bank holes, idle cycles with changing inputs, and back-to-back writes across banks.

// File: rtl/cbw_pkg.sv
package cbw_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned OFS_W  = 3;

   typedef enum logic [OFS_W-1:0] {
      OFS_CTRL = 3'd0,
      OFS_ADR2 = 3'd1,
      OFS_ADR1 = 3'd2,
      OFS_ADR0 = 3'd3,
      OFS_DAT1 = 3'd4,
      OFS_DAT0 = 3'd5,
      OFS_MSK1 = 3'd6,
      OFS_MSK0 = 3'd7
   } ofs_e;
endpackage

// File: rtl/cbw_bank.sv
module cbw_bank
   import cbw_pkg::*;
#(
   parameter bit          HAS_DATA   = 1'b1,
   parameter logic [7:0]  CTRL_MASK  = 8'hFF,
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned DATA_BYTES = 2,
   localparam int unsigned AW = ADDR_BYTES*BYTE_W,
   localparam int unsigned DW = DATA_BYTES*BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] ctrl,
   output logic [AW-1:0]     addr,
   output logic [DW-1:0]     data,
   output logic [DW-1:0]     mask,
   output logic [BYTE_W-1:0] rbyte
);
   localparam int unsigned DAT_BASE = 1 + ADDR_BYTES;
   localparam int unsigned MSK_BASE = DAT_BASE + DATA_BYTES;

   logic [BYTE_W-1:0] ctrl_q;
   logic [AW-1:0]     addr_q;
   logic [BYTE_W-1:0] rd_core;
   logic [BYTE_W-1:0] rd_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         addr_q <= '0;
      end else if (we) begin
         if (ofs == OFS_W'(0)) ctrl_q <= wdata & CTRL_MASK;
         for (int k = 0; k < ADDR_BYTES; k++) begin
            if (ofs == OFS_W'(k+1))
               addr_q[(ADDR_BYTES-1-k)*BYTE_W +: BYTE_W] <= wdata;
         end
      end
   end

   always_comb begin
      rd_core = '0;
      if (ofs == OFS_W'(0)) rd_core = ctrl_q;
      for (int k = 0; k < ADDR_BYTES; k++) begin
         if (ofs == OFS_W'(k+1))
            rd_core = addr_q[(ADDR_BYTES-1-k)*BYTE_W +: BYTE_W];
      end
   end

   generate
      if (HAS_DATA) begin : g_full
         logic [DW-1:0] data_q;
         logic [DW-1:0] mask_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q <= '0;
               mask_q <= '0;
            end else if (we) begin
               for (int k = 0; k < DATA_BYTES; k++) begin
                  if (ofs == OFS_W'(DAT_BASE+k))
                     data_q[(DATA_BYTES-1-k)*BYTE_W +: BYTE_W] <= wdata;
                  if (ofs == OFS_W'(MSK_BASE+k))
                     mask_q[(DATA_BYTES-1-k)*BYTE_W +: BYTE_W] <= wdata;
               end
            end
         end

         always_comb begin
            rd_ext = '0;
            for (int k = 0; k < DATA_BYTES; k++) begin
               if (ofs == OFS_W'(DAT_BASE+k))
                  rd_ext = data_q[(DATA_BYTES-1-k)*BYTE_W +: BYTE_W];
               if (ofs == OFS_W'(MSK_BASE+k))
                  rd_ext = mask_q[(DATA_BYTES-1-k)*BYTE_W +: BYTE_W];
            end
         end

         assign data = data_q;
         assign mask = mask_q;
      end else begin : g_reduced
         // Data and mask positions are holes: read zero, no storage.
         assign rd_ext = '0;
         assign data   = '0;
         assign mask   = '0;
      end
   endgenerate

   assign ctrl  = ctrl_q;
   assign addr  = addr_q;
   assign rbyte = (ofs >= OFS_W'(DAT_BASE)) ? rd_ext : rd_core;
endmodule

// File: rtl/cbw_rd_mux.sv
module cbw_rd_mux
   import cbw_pkg::*;
#(
   parameter int unsigned NBANK = 4,
   localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic [NBANK*BYTE_W-1:0] bytes_in,
   input  logic [SEL_W-1:0]        sel,
   output logic [BYTE_W-1:0]       rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NBANK; i++) begin
         if (sel == SEL_W'(i)) rdata = bytes_in[i*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/cbw_window.sv
module cbw_window
   import cbw_pkg::*;
#(
   parameter int unsigned NBANK      = 4,
   parameter logic [3:0]  FULL_MAP   = 4'b0101,
   parameter logic [7:0]  SMALL_CTRL = 8'hE7,
   parameter int unsigned ADDR_BYTES = 3,
   parameter int unsigned DATA_BYTES = 2,
   localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int unsigned AW    = ADDR_BYTES*BYTE_W,
   localparam int unsigned DW    = DATA_BYTES*BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SEL_W-1:0]      bank_sel,
   input  logic                  wr_en,
   input  logic [OFS_W-1:0]      offset,
   input  logic [BYTE_W-1:0]     wdata,
   output logic [BYTE_W-1:0]     rdata,
   output logic [NBANK*BYTE_W-1:0] ctrl_out,
   output logic [NBANK*AW-1:0]   addr_out,
   output logic [NBANK*DW-1:0]   data_out,
   output logic [NBANK*DW-1:0]   mask_out
);
   generate
      if (1 + ADDR_BYTES + 2*DATA_BYTES != (1 << OFS_W)) begin : g_bad_map
         $error("cbw_window: register bytes do not fill the window");
      end
      if (NBANK > 4 || NBANK < 1) begin : g_bad_nbank
         $error("cbw_window: NBANK must be 1..4");
      end
   endgenerate

   logic [NBANK*BYTE_W-1:0] rbytes;

   generate
      for (genvar i = 0; i < NBANK; i++) begin : g_bank
         cbw_bank #(
            .HAS_DATA   (FULL_MAP[i]),
            .CTRL_MASK  (FULL_MAP[i] ? 8'hFF : SMALL_CTRL),
            .ADDR_BYTES (ADDR_BYTES),
            .DATA_BYTES (DATA_BYTES)
         ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && (bank_sel == SEL_W'(i))),
            .ofs   (offset),
            .wdata (wdata),
            .ctrl  (ctrl_out[i*BYTE_W +: BYTE_W]),
            .addr  (addr_out[i*AW +: AW]),
            .data  (data_out[i*DW +: DW]),
            .mask  (mask_out[i*DW +: DW]),
            .rbyte (rbytes[i*BYTE_W +: BYTE_W])
         );
      end
   endgenerate

   cbw_rd_mux #(.NBANK(NBANK)) u_rd (
      .bytes_in (rbytes),
      .sel      (bank_sel),
      .rdata    (rdata)
   );
endmodule

// File: rtl/cbw_window_chk.sv
module cbw_window_chk #(
   parameter int unsigned NBANK      = 4,
   parameter logic [3:0]  FULL_MAP   = 4'b0101,
   parameter logic [7:0]  SMALL_CTRL = 8'hE7,
   parameter int unsigned AW         = 24,
   parameter int unsigned DW         = 16,
   localparam int unsigned SEL_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [SEL_W-1:0]     bank_sel,
   input logic                 wr_en,
   input logic [2:0]           offset,
   input logic [7:0]           wdata,
   input logic [NBANK*8-1:0]   ctrl_out,
   input logic [NBANK*AW-1:0]  addr_out,
   input logic [NBANK*DW-1:0]  data_out,
   input logic [NBANK*DW-1:0]  mask_out
);
   // R1: one edge after reset is sampled low, every output is clear.
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (ctrl_out == '0 && addr_out == '0 && data_out == '0 && mask_out == '0));

   // R8: no write strobe, no register change.
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(ctrl_out) && $stable(addr_out) && $stable(data_out) && $stable(mask_out)));

   generate
      for (genvar i = 0; i < NBANK; i++) begin : g_b
         // R2: banks that are not selected keep their values.
         a_r2_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && bank_sel != SEL_W'(i)) |=>
               ($stable(ctrl_out[i*8 +: 8]) && $stable(addr_out[i*AW +: AW])));
         if (!FULL_MAP[i]) begin : g_small
            // R4: holes on a reduced bank take no write.
            a_r4_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && bank_sel == SEL_W'(i) && offset >= 3'd4) |=>
                  ($stable(ctrl_out) && $stable(addr_out) && $stable(data_out) && $stable(mask_out)));
            // R5: reduced control byte keeps only the implemented bits.
            a_r5_small_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && bank_sel == SEL_W'(i) && offset == 3'd0) |=>
                  (ctrl_out[i*8 +: 8] == ($past(wdata) & SMALL_CTRL)));
         end else begin : g_full
            // R5: full control byte keeps all bits.
            a_r5_full_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en && bank_sel == SEL_W'(i) && offset == 3'd0) |=>
                  (ctrl_out[i*8 +: 8] == $past(wdata)));
         end
      end
   endgenerate
endmodule

bind cbw_window cbw_window_chk #(
   .NBANK(NBANK), .FULL_MAP(FULL_MAP), .SMALL_CTRL(SMALL_CTRL), .AW(AW), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .offset(offset),
   .wdata(wdata), .ctrl_out(ctrl_out), .addr_out(addr_out), .data_out(data_out),
   .mask_out(mask_out)
);

// File: tb/cbw_window_test.sv
`timescale 1ns/1ps
module cbw_window_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bank_sel = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  offset = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [31:0] ctrl_out;
   logic [95:0] addr_out;
   logic [63:0] data_out;
   logic [63:0] mask_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cbw_window uut (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .wr_en(wr_en), .offset(offset),
      .wdata(wdata), .rdata(rdata), .ctrl_out(ctrl_out), .addr_out(addr_out),
      .data_out(data_out), .mask_out(mask_out)
   );

   // {bank, offset, write data, expected read-back}
   localparam int NV = 12;
   localparam logic [20:0] VEC [NV] = '{
      {2'd0, 3'd0, 8'hA5, 8'hA5},
      {2'd1, 3'd0, 8'hFF, 8'hE7},
      {2'd2, 3'd1, 8'h12, 8'h12},
      {2'd2, 3'd2, 8'h34, 8'h34},
      {2'd2, 3'd3, 8'h56, 8'h56},
      {2'd3, 3'd4, 8'h77, 8'h00},
      {2'd3, 3'd7, 8'h88, 8'h00},
      {2'd0, 3'd4, 8'h9A, 8'h9A},
      {2'd0, 3'd7, 8'h3C, 8'h3C},
      {2'd1, 3'd3, 8'hC3, 8'hC3},
      {2'd3, 3'd0, 8'h18, 8'h00},
      {2'd2, 3'd6, 8'hF0, 8'hF0}
   };

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] b, input logic [2:0] o, input logic [7:0] d);
      @(negedge clk);
      bank_sel = b; offset = o; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] b, input logic [2:0] o, output logic [7:0] d);
      bank_sel = b; offset = o;
      #1;
      d = rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0]  r;
      logic [31:0] c_snap;
      logic [95:0] a_snap;
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 ctrl", ctrl_out, 0);
      check("R1 addr", addr_out, 0);
      check("R1 data/mask", {data_out, mask_out}, 0);
      rd(2'd0, 3'd5, r);
      check("R1 rdata", r, 0);
      rst_n = 1'b1;

      // R6 with R3/R4/R5: table walk, write then read back
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][20:19], VEC[i][18:16], VEC[i][15:8]);
         rd(VEC[i][20:19], VEC[i][18:16], r);
         check($sformatf("R6 vector %0d", i), r, VEC[i][7:0]);
      end

      // R3 and R9: output placement of the written values
      check("R3 addr bank2", addr_out[48 +: 24], 24'h123456);
      check("R3 data bank0", data_out[15:0], 16'h9A00);
      check("R3 mask bank0", mask_out[15:0], 16'h003C);
      check("R3 mask bank2", mask_out[47:32], 16'hF000);
      check("R9 ctrl all", ctrl_out, 32'h0000_E7A5);
      check("R9 addr bank1", addr_out[24 +: 24], 24'h0000C3);
      // R4: reduced bank data/mask outputs stay zero
      check("R4 small data", {data_out[63:48], data_out[31:16]}, 0);
      check("R4 small mask", {mask_out[63:48], mask_out[31:16]}, 0);
      // R2: other banks untouched (bank3 only had hole/ctrl writes)
      check("R2 bank3 addr", addr_out[72 +: 24], 0);

      // R5: full bank control keeps every bit
      wr(2'd2, 3'd0, 8'h18);
      check("R5 full ctrl", ctrl_out[23:16], 8'h18);

      // R8: idle cycles with moving inputs
      c_snap = ctrl_out; a_snap = addr_out;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         bank_sel = 2'(k); offset = 3'(k); wdata = 8'(8'h40 + k);
      end
      @(negedge clk);
      check("R8 ctrl stable", ctrl_out, c_snap);
      check("R8 addr stable", addr_out, a_snap);

      // R7: back-to-back writes to two banks
      @(negedge clk);
      bank_sel = 2'd1; offset = 3'd1; wdata = 8'h11; wr_en = 1'b1;
      @(negedge clk);
      bank_sel = 2'd3; wdata = 8'h22;
      @(negedge clk);
      wr_en = 1'b0;
      check("R7 bank1 high", addr_out[40 +: 8], 8'h11);
      check("R7 bank3 high", addr_out[88 +: 8], 8'h22);
      rd(2'd1, 3'd1, r);
      check("R7 read bank1", r, 8'h11);
      rd(2'd3, 3'd1, r);
      check("R7 read bank3", r, 8'h22);

      // R1: reset in mid-run clears everything
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid reset", {ctrl_out, addr_out, data_out, mask_out}, 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule